// File: doc/BRIEF.md
# Audio DMA Channel with Byte Countdown

This block is one direct-memory-access channel that carries audio frames between system memory and a stereo sample stream. Software loads a start address, a byte count and a control word. The control word sets the enable and the direction: playback moves memory to the sound side, capture moves the sound side to memory. The audio format is 48 kHz, two channels of signed 16-bit samples, so a stereo frame and a 32-bit memory word are the same 4 bytes.

The sound side offers service opportunities. Each one says how many bytes it can supply or take. The channel then moves the smaller of that figure and its remaining count. As each word goes, the address rises and the count falls. The work is split into chunks of a parameter size. At each chunk boundary the sound side may end the service early. When a service leaves the count at zero and the channel is still enabled, a one-cycle completion interrupt is raised.

Top module: `audio_dma_chan`

## Requirements
- R1: After reset the control bits, address and count read as zero. No memory request, sample handshake, busy flag or interrupt is active.
- R2: Configuration writes use selector 0 for control, 1 for address and 2 for count. In the control word, bit 0 is the enable and bit 1 chooses capture (1) or playback (0). Address and count writes clear the two low bits, so they land on a word boundary.
- R3: A service request starts a transfer of min(count, offered bytes)/4 words, but only while the channel is enabled and idle. A request while disabled changes nothing.
- R4: If that word figure is zero, no memory or sample traffic occurs, address and count stay unchanged, and no interrupt is raised.
- R5: Playback reads the word at the current address. It presents bits 31:16 as the left sample and bits 15:0 as the right sample.
- R6: Capture writes each accepted frame to the current address, with the left sample in bits 31:16 and the right sample in bits 15:0.
- R7: Each completed word adds 4 to the address and subtracts 4 from the count. After a service both have moved by exactly the bytes transferred.
- R8: A completion interrupt is a single-cycle pulse. It is issued after a service only when the channel is enabled and the count is zero.
- R9: After every CHUNK_BYTES bytes of a service, the service ends early if the stop input from the sound side is high.
- R10: Clearing the enable during a service lets the current word finish. The channel then halts with no interrupt.
- R11: Address and count writes made while a service is in progress are ignored.
- R12: A memory request holds its address and direction until granted. At most one of the memory request, playback valid and capture ready is active in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 control, 1 address, 2 count |
| cfg_wdata | input | 32 | Configuration write data |
| ctrl_en_o | output | 1 | Current enable bit |
| ctrl_cap_o | output | 1 | Current direction bit (1 = capture) |
| addr_o | output | ADDR_W | Current memory address |
| remain_o | output | CNT_W | Remaining byte count |
| svc_start | input | 1 | Service opportunity from the sound side |
| svc_bytes | input | CNT_W | Bytes the sound side can take or give in this service |
| snd_stop | input | 1 | Sound side cannot continue; checked at chunk boundaries |
| busy_o | output | 1 | Service in progress |
| irq_done | output | 1 | Completion interrupt pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory grant; read data is valid in the same cycle |
| mem_rdata | input | 32 | Memory read data |
| play_valid | output | 1 | Playback frame valid |
| play_ready | input | 1 | Sound side accepts the playback frame |
| play_left | output | 16 | Playback left sample |
| play_right | output | 16 | Playback right sample |
| cap_valid | input | 1 | Capture frame valid |
| cap_ready | output | 1 | Channel accepts a capture frame |
| cap_left | input | 16 | Capture left sample |
| cap_right | input | 16 | Capture right sample |

## Verification
Several rules are checked by assertions on every cycle. A word handshake moves the address and count by exactly one word. The interrupt is only a single-cycle pulse, and only with a zero count and the enable set. A pending memory request keeps its address until granted, and the three traffic strobes never overlap. A cleared enable stops the sequencer after the word in flight. Other behaviour can only be shown by the bench's scenarios. These are the word counts that follow from the minimum rule, the chunk-boundary early stop, the frame packing seen end to end through memory, the dropped address writes during a service, and the exact remaining count after a mid-service disable.

// File: rtl/audma_pkg.sv
package audma_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,     // playback: fetching word from memory
        ST_PLAY,   // playback: offering frame to sound side
        ST_CAPT,   // capture: waiting for frame from sound side
        ST_WR,     // capture: storing word to memory
        ST_FIN     // service ended, completion decision cycle
    } seq_st_t;

    // Configuration write targets
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_t;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CAP_BIT = 1;
    localparam int BYTES_PER_WORD = 4;

    // One stereo frame: left in the upper half of the word
    typedef struct packed {
        logic [15:0] left;
        logic [15:0] right;
    } frame_t;

    // Whole words movable in one service
    function automatic logic [31:0] min_words(input logic [31:0] cnt,
                                              input logic [31:0] avail);
        logic [31:0] m;
        m = (cnt < avail) ? cnt : avail;
        return m >> 2;
    endfunction

endpackage

// File: rtl/audma_regs.sv
module audma_regs
    import audma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  cfg_sel_t          cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              busy,
    input  logic              adv,
    output logic              en,
    output logic              cap,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  cnt_q
);

    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(BYTES_PER_WORD);
    localparam logic [CNT_W-1:0]  CNT_STEP  = CNT_W'(BYTES_PER_WORD);

    logic wr_ctrl, wr_addr, wr_cnt;

    always_comb begin
        wr_ctrl = cfg_we && (cfg_sel == SEL_CTRL);
        wr_addr = cfg_we && (cfg_sel == SEL_ADDR) && !busy;
        wr_cnt  = cfg_we && (cfg_sel == SEL_CNT)  && !busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en  <= 1'b0;
            cap <= 1'b0;
        end else if (wr_ctrl) begin
            en  <= cfg_wdata[CTRL_EN_BIT];
            cap <= cfg_wdata[CTRL_CAP_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (adv) begin
            addr_q <= addr_q + ADDR_STEP;
            cnt_q  <= cnt_q - CNT_STEP;
        end else begin
            if (wr_addr) addr_q <= {cfg_wdata[ADDR_W-1:2], 2'b00};
            if (wr_cnt)  cnt_q  <= {cfg_wdata[CNT_W-1:2], 2'b00};
        end
    end

    // R11: software cannot move the pointers while a service runs
    a_r11_hold_busy: assert property (@(posedge clk) disable iff (rst)
        busy && !adv |=> $stable(addr_q) && $stable(cnt_q));

endmodule

// File: rtl/audma_seq.sv
module audma_seq
    import audma_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int CHUNK_BYTES = 4096
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             cap_cfg,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             svc_start,
    input  logic [CNT_W-1:0] svc_bytes,
    input  logic             snd_stop,
    input  logic             mem_gnt,
    input  logic [31:0]      mem_rdata,
    input  logic             play_ready,
    input  logic             cap_valid,
    input  frame_t           cap_frame,
    output logic             adv,
    output logic             busy,
    output logic             irq,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_wdata,
    output logic             play_valid,
    output frame_t           play_frame,
    output logic             cap_ready
);

    localparam int CHUNK_WORDS = CHUNK_BYTES / BYTES_PER_WORD;
    localparam int CHK_W       = $clog2(CHUNK_WORDS + 1);
    localparam logic [CHK_W-1:0] CHUNK_LOAD = CHK_W'(CHUNK_WORDS);

    seq_st_t          st, st_after;
    logic             cap_mode;
    logic [CNT_W-1:0] words_left;
    logic [CHK_W-1:0] chunk_left;
    frame_t           stage;
    logic [CNT_W-1:0] start_words;
    logic             cnt_zero;

    always_comb begin
        start_words = CNT_W'(min_words(32'(cnt_q), 32'(svc_bytes)));
        cnt_zero    = (cnt_q == '0);
        adv = ((st == ST_PLAY) && play_ready) || ((st == ST_WR) && mem_gnt);
    end

    // Where to go once the word in flight completes
    always_comb begin
        if (!en)
            st_after = ST_IDLE;
        else if (words_left == CNT_W'(1))
            st_after = ST_FIN;
        else if ((chunk_left == CHK_W'(1)) && snd_stop)
            st_after = ST_FIN;
        else
            st_after = cap_mode ? ST_CAPT : ST_RD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cap_mode   <= 1'b0;
            words_left <= '0;
            chunk_left <= '0;
            stage      <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (svc_start && en && (start_words != '0)) begin
                        words_left <= start_words;
                        chunk_left <= CHUNK_LOAD;
                        cap_mode   <= cap_cfg;
                        st         <= cap_cfg ? ST_CAPT : ST_RD;
                    end
                end
                ST_RD: begin
                    if (mem_gnt) begin
                        stage <= frame_t'(mem_rdata);
                        st    <= ST_PLAY;
                    end
                end
                ST_PLAY: if (play_ready) st <= st_after;
                ST_CAPT: begin
                    if (cap_valid) begin
                        stage <= cap_frame;
                        st    <= ST_WR;
                    end
                end
                ST_WR:   if (mem_gnt) st <= st_after;
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
            if (adv) begin
                words_left <= words_left - CNT_W'(1);
                chunk_left <= (chunk_left == CHK_W'(1)) ? CHUNK_LOAD
                                                        : chunk_left - CHK_W'(1);
            end
        end
    end

    always_comb begin
        busy       = (st != ST_IDLE);
        irq        = (st == ST_FIN) && en && cnt_zero;
        mem_req    = (st == ST_RD) || (st == ST_WR);
        mem_we     = (st == ST_WR);
        mem_wdata  = stage;
        play_valid = (st == ST_PLAY);
        play_frame = stage;
        cap_ready  = (st == ST_CAPT);
    end

    // R8: completion is a single-cycle pulse
    a_r8_irq_pulse: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R3: a service only begins while the channel is enabled
    a_r3_start_enabled: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(en));

    // R10: a cleared enable halts after the word in flight
    a_r10_halt: assert property (@(posedge clk) disable iff (rst)
        adv && !en |=> !busy && !irq);

endmodule

// File: rtl/audio_dma_chan.sv
module audio_dma_chan
    import audma_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 24,
    parameter int CHUNK_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic              ctrl_en_o,
    output logic              ctrl_cap_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  remain_o,
    input  logic              svc_start,
    input  logic [CNT_W-1:0]  svc_bytes,
    input  logic              snd_stop,
    output logic              busy_o,
    output logic              irq_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic [31:0]       mem_rdata,
    output logic              play_valid,
    input  logic              play_ready,
    output logic [15:0]       play_left,
    output logic [15:0]       play_right,
    input  logic              cap_valid,
    output logic              cap_ready,
    input  logic [15:0]       cap_left,
    input  logic [15:0]       cap_right
);

    logic   adv, busy, en, cap;
    frame_t cap_frame, play_frame;

    assign cap_frame = '{left: cap_left, right: cap_right};

    audma_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) regs_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel_t'(cfg_sel)),
        .cfg_wdata (cfg_wdata),
        .busy      (busy),
        .adv       (adv),
        .en        (en),
        .cap       (cap),
        .addr_q    (addr_o),
        .cnt_q     (remain_o)
    );

    audma_seq #(
        .CNT_W       (CNT_W),
        .CHUNK_BYTES (CHUNK_BYTES)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .cap_cfg    (cap),
        .cnt_q      (remain_o),
        .svc_start  (svc_start),
        .svc_bytes  (svc_bytes),
        .snd_stop   (snd_stop),
        .mem_gnt    (mem_gnt),
        .mem_rdata  (mem_rdata),
        .play_ready (play_ready),
        .cap_valid  (cap_valid),
        .cap_frame  (cap_frame),
        .adv        (adv),
        .busy       (busy),
        .irq        (irq_done),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .play_valid (play_valid),
        .play_frame (play_frame),
        .cap_ready  (cap_ready)
    );

    assign ctrl_en_o  = en;
    assign ctrl_cap_o = cap;
    assign busy_o     = busy;
    assign mem_addr   = addr_o;
    assign play_left  = play_frame.left;
    assign play_right = play_frame.right;

    // R7: every word handshake moves both pointers by one word
    a_r7_word_step: assert property (@(posedge clk) disable iff (rst)
        (play_valid && play_ready) || (mem_req && mem_we && mem_gnt) |=>
            (remain_o == $past(remain_o) - CNT_W'(4)) &&
            (addr_o == $past(addr_o) + ADDR_W'(4)));

    // R8: the interrupt only fires with an empty count on an enabled channel
    a_r8_irq_zero: assert property (@(posedge clk) disable iff (rst)
        irq_done |-> (remain_o == '0) && ctrl_en_o);

    // R12: a pending memory request is held unchanged until granted
    a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R12: only one kind of traffic at a time
    a_r12_one_port: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_req, play_valid, cap_ready}));

endmodule

// File: tb/audio_dma_chan_tb_top.sv
module audio_dma_chan_tb_top;

    localparam int ADDR_W = 16;
    localparam int CNT_W  = 16;
    localparam int CHUNK  = 16;   // 4 words per chunk

    logic              clk = 1'b0;
    logic              rst;
    logic              cfg_we;
    logic [1:0]        cfg_sel;
    logic [31:0]       cfg_wdata;
    logic              ctrl_en_o, ctrl_cap_o;
    logic [ADDR_W-1:0] addr_o;
    logic [CNT_W-1:0]  remain_o;
    logic              svc_start;
    logic [CNT_W-1:0]  svc_bytes;
    logic              snd_stop;
    logic              busy_o, irq_done;
    logic              mem_req, mem_we, mem_gnt;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata, mem_rdata;
    logic              play_valid, play_ready;
    logic [15:0]       play_left, play_right;
    logic              cap_valid, cap_ready;
    logic [15:0]       cap_left, cap_right;

    always #2 clk = ~clk;   // 250 MHz

    audio_dma_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CHUNK_BYTES(CHUNK)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ctrl_en_o(ctrl_en_o), .ctrl_cap_o(ctrl_cap_o), .addr_o(addr_o), .remain_o(remain_o),
        .svc_start(svc_start), .svc_bytes(svc_bytes), .snd_stop(snd_stop),
        .busy_o(busy_o), .irq_done(irq_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .play_valid(play_valid), .play_ready(play_ready),
        .play_left(play_left), .play_right(play_right),
        .cap_valid(cap_valid), .cap_ready(cap_ready),
        .cap_left(cap_left), .cap_right(cap_right));

    int nvec = 0, nerr = 0;
    int irq_cnt = 0, play_cnt = 0, cap_hs_cnt = 0;
    logic [31:0] mem [256];
    logic [31:0] play_q[$];
    logic [31:0] wr_addr_q[$];
    logic [31:0] wr_data_q[$];
    bit stall_en = 0, ready_hold = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] m_addr, m_cnt, m_ctrl;

    assign mem_rdata = mem[mem_addr[9:2]];

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cap_word(input int s);
        logic [15:0] v;
        v = 16'(s);
        return {v, v ^ 16'h5A5A};
    endfunction

    // Sound-side and memory-side drivers, away from the edge
    initial begin
        mem_gnt = 0; play_ready = 0; cap_valid = 0; cap_left = 0; cap_right = 0;
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_gnt    = stall_en ? lfsr[0] : 1'b1;
            play_ready = ready_hold ? 1'b0 : (stall_en ? lfsr[3] : 1'b1);
            cap_valid  = stall_en ? lfsr[6] : 1'b1;
            {cap_left, cap_right} = cap_word(cap_hs_cnt);
        end
    end

    // Memory model and scoreboard monitor
    initial begin
        for (int i = 0; i < 256; i++)
            mem[i] = {8'(i), 8'hC3, 8'(~i), 8'(i * 3)};
        forever begin
            @(negedge clk);
            if (irq_done) irq_cnt++;
            if (play_valid && play_ready) begin
                play_cnt++;
                if (play_q.size() == 0)
                    chk(0, "R5 unexpected playback frame", {play_left, play_right}, 0);
                else begin
                    logic [31:0] e;
                    e = play_q.pop_front();
                    chk({play_left, play_right} == e, "R5 playback frame",
                        {play_left, play_right}, e);
                end
            end
            if (cap_valid && cap_ready) cap_hs_cnt++;
            if (mem_req && mem_we && mem_gnt) begin
                if (wr_addr_q.size() == 0)
                    chk(0, "R6 unexpected memory write", 32'(mem_addr), 0);
                else begin
                    logic [31:0] ea, ed;
                    ea = wr_addr_q.pop_front();
                    ed = wr_data_q.pop_front();
                    chk(32'(mem_addr) == ea, "R6 capture address", 32'(mem_addr), ea);
                    chk(mem_wdata == ed, "R6 capture word", mem_wdata, ed);
                end
                mem[mem_addr[9:2]] = mem_wdata;
            end
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 0;
    endtask

    task automatic setup(input logic [31:0] a, input logic [31:0] c, input logic [31:0] ctl);
        cfg_write(2'd0, ctl);
        cfg_write(2'd1, a);
        cfg_write(2'd2, c);
        m_addr = a & ~32'd3; m_cnt = c & ~32'd3; m_ctrl = ctl;
    endtask

    task automatic pulse_start(input logic [31:0] bytes);
        @(posedge clk); #1;
        svc_start = 1; svc_bytes = CNT_W'(bytes);
        @(posedge clk); #1;
        svc_start = 0;
    endtask

    // Driver: predicts the service and pushes expected items
    task automatic run_svc(input logic [31:0] bytes, input bit stop, input string tag);
        int n, irq0, base, exp_irq;
        n = int'(((m_cnt < bytes) ? m_cnt : bytes) >> 2);
        if (stop && n > CHUNK / 4) n = CHUNK / 4;
        if (!m_ctrl[0]) n = 0;
        base = cap_hs_cnt;
        for (int k = 0; k < n; k++) begin
            if (m_ctrl[1]) begin
                wr_addr_q.push_back(m_addr + 32'(4 * k));
                wr_data_q.push_back(cap_word(base + k));
            end else
                play_q.push_back(mem[8'((m_addr >> 2) + 32'(k))]);
        end
        exp_irq = (n > 0 && m_cnt - 32'(4 * n) == 0) ? 1 : 0;
        irq0 = irq_cnt;
        pulse_start(bytes);
        @(negedge clk);
        while (busy_o) @(negedge clk);
        @(negedge clk);
        m_addr = m_addr + 32'(4 * n);
        m_cnt  = m_cnt - 32'(4 * n);
        chk(32'(addr_o) == m_addr, {tag, " R7 address"}, 32'(addr_o), m_addr);
        chk(32'(remain_o) == m_cnt, {tag, " R7 count"}, 32'(remain_o), m_cnt);
        chk(irq_cnt - irq0 == exp_irq, {tag, " R8 interrupt count"},
            32'(irq_cnt - irq0), 32'(exp_irq));
        chk(play_q.size() == 0 && wr_addr_q.size() == 0, {tag, " R3 words left over"},
            32'(play_q.size() + wr_addr_q.size()), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        int p0, i0;
        rst = 1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
        svc_start = 0; svc_bytes = 0; snd_stop = 0;
        repeat (4) @(posedge clk); #1;
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(addr_o == 0 && remain_o == 0, "R1 pointers", {addr_o, remain_o}, 0);
        chk(!ctrl_en_o && !ctrl_cap_o, "R1 control", {ctrl_en_o, ctrl_cap_o}, 0);
        chk(!busy_o && !irq_done && !mem_req && !play_valid && !cap_ready,
            "R1 idle outputs", {busy_o, irq_done, mem_req, play_valid, cap_ready}, 0);

        // R5 plain playback that empties the count
        setup(32'h040, 32, 1);
        chk(ctrl_en_o && !ctrl_cap_o, "R2 control bits", {ctrl_en_o, ctrl_cap_o}, 1);
        run_svc(64, 0, "playback full");

        // R3 service bounded by availability, with stalls
        stall_en = 1;
        setup(32'h080, 40, 1);
        run_svc(14, 0, "bounded");
        // R4 zero offered bytes, then zero count
        run_svc(0, 0, "R4 zero avail");
        setup(32'h080, 0, 1);
        run_svc(64, 0, "R4 zero count");

        // R2 misaligned values truncated to the word
        setup(32'h103, 32'h1B, 1);
        chk(addr_o == 16'h100, "R2 address truncation", 32'(addr_o), 32'h100);
        chk(remain_o == 16'h18, "R2 count truncation", 32'(remain_o), 32'h18);
        run_svc(7, 0, "R2 one word");

        // R9 early stop at the chunk boundary, then continue across chunks
        snd_stop = 1;
        setup(32'h200, 64, 1);
        run_svc(64, 1, "R9 stop");
        snd_stop = 0;
        run_svc(64, 0, "R9 continue");

        // R6 capture, then read the same words back through playback
        setup(32'h300, 24, 3);
        chk(ctrl_cap_o, "R2 capture bit", 32'(ctrl_cap_o), 1);
        run_svc(100, 0, "R6 capture");
        setup(32'h300, 24, 1);
        run_svc(24, 0, "R6 readback");

        // R3 request ignored while disabled
        setup(32'h100, 32, 0);
        run_svc(32, 0, "R3 disabled");

        // R11 address and count writes during a service are dropped
        setup(32'h140, 32, 1);
        fork
            run_svc(32, 0, "R11 write while busy");
            begin
                repeat (3) @(posedge clk);
                cfg_write(2'd1, 32'h3F0);
                cfg_write(2'd2, 32'h40);
            end
        join

        // R10 disable in the middle of a word
        stall_en = 0; ready_hold = 1;
        setup(32'h180, 64, 1);
        for (int k = 0; k < 16; k++) play_q.push_back(mem[8'(32'h60 + k)]);
        p0 = play_cnt; i0 = irq_cnt;
        pulse_start(64);
        repeat (5) @(posedge clk);
        cfg_write(2'd0, 0);
        ready_hold = 0;
        repeat (6) @(negedge clk);
        chk(!busy_o, "R10 halted", 32'(busy_o), 0);
        chk(play_cnt - p0 == 1, "R10 words moved", 32'(play_cnt - p0), 1);
        chk(remain_o == 16'd60, "R10 count", 32'(remain_o), 60);
        chk(addr_o == 16'h184, "R10 address", 32'(addr_o), 32'h184);
        chk(irq_cnt == i0, "R10 no interrupt", 32'(irq_cnt - i0), 0);
        play_q.delete();

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule